// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Line Maintenance Commands

This block is a small direct-mapped data cache that sits between a core and a line-wide backing memory. The core issues one request at a time on a valid/ready handshake. A request is a word load, a word store, or one of three line-maintenance commands: discard a line, write a line back while keeping it, or write it back and then discard it. Stores are held in the cache, which marks the line dirty. A dirty line reaches memory only when it is evicted by a conflicting miss or when a maintenance command pushes it out.

Each line holds sixteen 32-bit words (64 bytes). A maintenance command acts on the whole line that contains the given address and never touches the next line. An address window, set by parameters, marks memory that must not be cached. A maintenance command aimed into that window is refused and returns an exception flag instead of completing normally.

The controller is a five-state machine. IDLE accepts a request (IDLE to LOOKUP). LOOKUP decides the action: LOOKUP to DONE on a hit, on a command that needs no memory traffic, or on a refused command; LOOKUP to WRBACK when a dirty line must be written out; LOOKUP to FILL on a miss with a clean or empty victim. WRBACK writes the line out, then goes to FILL for a load or store miss, or to DONE for a command. FILL loads the line and returns to LOOKUP, where the load or store now hits. DONE gives a one-cycle response and returns to IDLE.

Top module: `wbc_cache`

## Requirements
- R1: Load (op code 0) returns the 32-bit word selected by address bits [5:2] of the line chosen by address bits [8:6] (defaults). A hit completes with no memory traffic. A miss fills the line first: word k of a memory line sits at bits [32k+31:32k]. rsp_rdata is zero for every non-load request.
- R2: Store (op code 1) on a hit writes the word and marks the line dirty, with no memory traffic. On a miss it fills the line first and then applies the store. Backing memory keeps its old value until the line is written back.
- R3: On a load or store miss whose victim is valid and dirty, the victim is written back to its own line address before the fill. A clean or empty victim is not written back. mem_req, mem_we and mem_addr stay steady until mem_ready.
- R4: Invalidate (op code 2) clears valid and dirty on the addressed line with no writeback. Stores held only in the cache are lost, and the next load refetches memory contents.
- R5: Clean (op code 3) writes the addressed line back only if it is dirty, then clears dirty. The line stays valid, so a later load hits.
- R6: Flush (op code 4) writes the addressed line back if it is dirty. The line then ends up neither valid nor dirty, whether or not a writeback happened.
- R7: A maintenance command on a line that is not present, including a second invalidate, produces no memory traffic and rsp_fault = 0.
- R8: A maintenance command leaves the following 64-byte line's valid bit, dirty bit and data unchanged.
- R9: A maintenance command whose address lies in [UNC_BASE, UNC_LAST] responds with rsp_fault = 1, causes no memory traffic and changes no line. Loads and stores always respond with rsp_fault = 0.
- R10: req_ready is high only when the controller is idle. It drops from the accepting edge until the response. Each accepted request gets exactly one single-cycle rsp_valid pulse.
- R11: Reset leaves every line invalid and clean with no memory traffic, so the first load after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_op | input | 3 | 0 load, 1 store, 2 invalidate, 3 clean, 4 flush |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, zero otherwise |
| rsp_fault | output | 1 | Command refused for an uncached address |
| mem_req | output | 1 | Memory line access pending |
| mem_we | output | 1 | 1 write-back, 0 fill |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wline | output | 512 | Line written back |
| mem_rline | input | 512 | Line returned by a fill |
| mem_ready | input | 1 | Memory access done this cycle |

## Verification
Two actions can land on the same clock edge. When a flush writeback finishes, the dirty bit is cleared and the line is invalidated on one edge. When a clean writeback finishes, only the dirty bit is cleared. Each case is set up by storing into a line and then issuing the command. The result is judged from backing-memory contents, the count of writebacks and fills, and whether the next load to that line triggers a fill. A store miss with a dirty victim is judged the same way: the victim writeback, the fill and the store itself all happen within one request.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_INVAL = 3'd2,
        OP_CLEAN = 3'd3,
        OP_FLUSH = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRBACK,
        S_FILL,
        S_DONE
    } state_e;

    function automatic logic is_maint(input logic [2:0] op);
        return (op == OP_INVAL) || (op == OP_CLEAN) || (op == OP_FLUSH);
    endfunction

endpackage

// File: rtl/wbc_region_check.sv
module wbc_region_check #(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] UNC_BASE = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] UNC_LAST = 32'hF0FF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              uncached
);
    always_comb begin
        uncached = (addr >= UNC_BASE) && (addr <= UNC_LAST);
    end
endmodule

// File: rtl/wbc_store.sv
module wbc_store #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned LINE_WDS  = 16,
    parameter int unsigned TAG_W     = 23,
    localparam int unsigned IDX_W     = $clog2(NUM_LINES),
    localparam int unsigned WOFF_W    = $clog2(LINE_WDS),
    localparam int unsigned LINE_BITS = WORD_W * LINE_WDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx,
    input  logic [WOFF_W-1:0]    woff,
    input  logic                 fill_en,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic                 word_en,
    input  logic [WORD_W-1:0]    word_data,
    input  logic                 clr_dirty,
    input  logic                 clr_valid,
    output logic                 rd_valid,
    output logic                 rd_dirty,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [LINE_BITS-1:0] rd_line
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_BITS-1:0] line_q [NUM_LINES];

    // state bits: the only storage that reset touches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (word_en)   dirty_q[idx] <= 1'b1;
            if (clr_dirty) dirty_q[idx] <= 1'b0;
            if (clr_valid) begin
                valid_q[idx] <= 1'b0;
                dirty_q[idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= fill_tag;
            line_q[idx] <= fill_line;
        end
        if (word_en) line_q[idx][WORD_W*int'(woff) +: WORD_W] <= word_data;
    end

    always_comb begin
        rd_valid = valid_q[idx];
        rd_dirty = dirty_q[idx];
        rd_tag   = tag_q[idx];
        rd_line  = line_q[idx];
    end

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0); // R4

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned LINE_WDS  = 16,
    parameter int unsigned NUM_LINES = 8,
    parameter logic [ADDR_W-1:0] UNC_BASE = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] UNC_LAST = 32'hF0FF_FFFF,
    localparam int unsigned LINE_BITS = WORD_W * LINE_WDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 rsp_fault,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LINE_BITS-1:0] mem_wline,
    input  logic [LINE_BITS-1:0] mem_rline,
    input  logic                 mem_ready
);
    localparam int unsigned BOFF_W = $clog2(WORD_W / 8);
    localparam int unsigned WOFF_W = $clog2(LINE_WDS);
    localparam int unsigned OFF_W  = BOFF_W + WOFF_W;
    localparam int unsigned IDX_W  = $clog2(NUM_LINES);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;

    state_e state_q, state_d;

    logic [2:0]         op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic [WORD_W-1:0]  rdata_q;
    logic               fault_q;

    logic [IDX_W-1:0]   idx_q;
    logic [WOFF_W-1:0]  woff_q;
    logic [TAG_W-1:0]   tag_q;

    logic                 st_valid, st_dirty;
    logic [TAG_W-1:0]     st_tag;
    logic [LINE_BITS-1:0] st_line;
    logic                 fill_en, word_en, clr_dirty, clr_valid;
    logic                 hit, maint, uncached;
    logic [WORD_W-1:0]    word_sel;

    assign idx_q  = addr_q[OFF_W +: IDX_W];
    assign woff_q = addr_q[BOFF_W +: WOFF_W];
    assign tag_q  = addr_q[ADDR_W-1 -: TAG_W];

    wbc_region_check #(
        .ADDR_W   (ADDR_W),
        .UNC_BASE (UNC_BASE),
        .UNC_LAST (UNC_LAST)
    ) u_region (
        .addr     (addr_q),
        .uncached (uncached)
    );

    wbc_store #(
        .NUM_LINES (NUM_LINES),
        .WORD_W    (WORD_W),
        .LINE_WDS  (LINE_WDS),
        .TAG_W     (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx_q),
        .woff      (woff_q),
        .fill_en   (fill_en),
        .fill_tag  (tag_q),
        .fill_line (mem_rline),
        .word_en   (word_en),
        .word_data (wdata_q),
        .clr_dirty (clr_dirty),
        .clr_valid (clr_valid),
        .rd_valid  (st_valid),
        .rd_dirty  (st_dirty),
        .rd_tag    (st_tag),
        .rd_line   (st_line)
    );

    assign hit      = st_valid && (st_tag == tag_q);
    assign maint    = is_maint(op_q);
    assign word_sel = st_line[WORD_W*int'(woff_q) +: WORD_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_LOOKUP;
            S_LOOKUP: begin
                if (maint) begin
                    if (uncached || !hit)                  state_d = S_DONE;
                    else if (op_q != OP_INVAL && st_dirty) state_d = S_WRBACK;
                    else                                   state_d = S_DONE;
                end else if (hit)                          state_d = S_DONE;
                else if (st_valid && st_dirty)             state_d = S_WRBACK;
                else                                       state_d = S_FILL;
            end
            S_WRBACK: if (mem_ready) state_d = maint ? S_DONE : S_FILL;
            S_FILL:   if (mem_ready) state_d = S_LOOKUP;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and line-state controls
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_DONE);
        rsp_rdata = rdata_q;
        rsp_fault = fault_q;
        mem_req   = (state_q == S_WRBACK) || (state_q == S_FILL);
        mem_we    = (state_q == S_WRBACK);
        mem_addr  = (state_q == S_WRBACK) ? {st_tag, idx_q, {OFF_W{1'b0}}}
                                          : {tag_q,  idx_q, {OFF_W{1'b0}}};
        mem_wline = st_line;
        fill_en   = (state_q == S_FILL) && mem_ready;
        word_en   = (state_q == S_LOOKUP) && hit && (op_q == OP_STORE);
        clr_dirty = (state_q == S_WRBACK) && mem_ready;
        clr_valid = ((state_q == S_LOOKUP) && maint && !uncached && hit &&
                     ((op_q == OP_INVAL) || ((op_q == OP_FLUSH) && !st_dirty))) ||
                    ((state_q == S_WRBACK) && mem_ready && (op_q == OP_FLUSH));
    end

    // request capture and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            fault_q <= 1'b0;
        end else if (state_q == S_IDLE && req_valid) begin
            op_q    <= req_op;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            fault_q <= 1'b0;
        end else if (state_q == S_LOOKUP) begin
            if (maint)                         fault_q <= uncached;
            else if (hit && op_q == OP_LOAD)   rdata_q <= word_sel;
        end
    end

    AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && mem_ready) |=> (hit && !st_dirty)); // R1
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (st_valid && st_dirty)); // R3
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
    AST_INVAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOOKUP && op_q == OP_INVAL) |=> !mem_req); // R4
    AST_CLEAN_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRBACK && mem_ready && op_q == OP_CLEAN) |=> (st_valid && !st_dirty)); // R5
    AST_FLUSH_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRBACK && mem_ready && op_q == OP_FLUSH) |=> !st_valid); // R6
    AST_FAULT_ONLY_MAINT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> is_maint(op_q)); // R9
    AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOOKUP && maint && uncached) |=> !mem_req); // R9
    AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R10

endmodule

// File: tb/wbc_cache_bench.sv
module wbc_cache_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [2:0]   req_op;
    logic [31:0]  req_addr;
    logic [31:0]  req_wdata;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         rsp_fault;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wline;
    logic [511:0] mem_rline;
    logic         mem_ready;

    wbc_cache u_wbc_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ready(mem_ready)
    );

    // backing memory model, 4 KiB, two-cycle latency
    logic [31:0] bmem [0:1023];
    int wb_cnt = 0;
    int fill_cnt = 0;
    int mem_wait = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_wait  <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            mem_wait  <= 0;
        end else if (mem_req) begin
            if (mem_wait == 2) begin
                mem_ready <= 1'b1;
                if (mem_we) begin
                    for (int k = 0; k < 16; k++)
                        bmem[mem_addr[11:2] + 10'(k)] <= mem_wline[k*32 +: 32];
                    wb_cnt <= wb_cnt + 1;
                end else begin
                    for (int k = 0; k < 16; k++)
                        mem_rline[k*32 +: 32] <= bmem[mem_addr[11:2] + 10'(k)];
                    fill_cnt <= fill_cnt + 1;
                end
            end else begin
                mem_wait <= mem_wait + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // scoreboard: {fault, data}
    logic [32:0] exp_q [$];
    string       rq_q  [$];
    logic [32:0] exp_e;
    string       exp_r;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "response without request", 32'd1, 32'd0);
            end else begin
                exp_e = exp_q.pop_front();
                exp_r = rq_q.pop_front();
                check(rsp_rdata == exp_e[31:0], exp_r, "rsp_rdata", rsp_rdata, exp_e[31:0]);
                check(rsp_fault == exp_e[32], exp_r, "rsp_fault",
                      {31'd0, rsp_fault}, {31'd0, exp_e[32]});
            end
        end
    end

    int w0, f0;

    task automatic snap();
        w0 = wb_cnt;
        f0 = fill_cnt;
    endtask

    task automatic traffic(input int dwb, input int dfill, input string rq);
        check(wb_cnt - w0 == dwb, rq, "writebacks", 32'(wb_cnt - w0), 32'(dwb));
        check(fill_cnt - f0 == dfill, rq, "fills", 32'(fill_cnt - f0), 32'(dfill));
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] addr,
                         input logic [31:0] wd, input logic [31:0] exp_d,
                         input logic exp_f, input string rq);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_wdata = wd;
        exp_q.push_back({exp_f, exp_d});
        rq_q.push_back(rq);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready low while busy", {31'd0, req_ready}, 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] bval(input logic [31:0] a);
        return 32'hA000_0000 + (a >> 2);
    endfunction

    localparam logic [2:0] LD = 3'd0, ST = 3'd1, INV = 3'd2, CLN = 3'd3, FLU = 3'd4;

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 32'hA000_0000 + i;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(req_ready == 1'b1, "R11", "ready after reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R11", "no response after reset", {31'd0, rsp_valid}, 32'd0);
        check(mem_req == 1'b0, "R11", "no memory request after reset", {31'd0, mem_req}, 32'd0);

        // R1 / R11 first load misses and fills
        snap(); issue(LD, 32'h004, 0, bval(32'h004), 0, "R1");
        traffic(0, 1, "R11");
        snap(); issue(LD, 32'h008, 0, bval(32'h008), 0, "R1");
        traffic(0, 0, "R1");

        // R2 store hit
        snap(); issue(ST, 32'h004, 32'h1111_1111, 0, 0, "R2");
        issue(LD, 32'h004, 0, 32'h1111_1111, 0, "R2");
        traffic(0, 0, "R2");
        check(bmem[1] == bval(32'h004), "R2", "memory untouched by store", bmem[1], bval(32'h004));

        // neighbour line B dirty
        issue(LD, 32'h044, 0, bval(32'h044), 0, "R1");
        issue(ST, 32'h048, 32'h2222_2222, 0, 0, "R2");

        // R4 invalidate drops store; R8 neighbour intact
        snap(); issue(INV, 32'h000, 0, 0, 0, "R4");
        traffic(0, 0, "R4");
        snap(); issue(LD, 32'h004, 0, bval(32'h004), 0, "R4");
        traffic(0, 1, "R4");
        snap(); issue(LD, 32'h048, 0, 32'h2222_2222, 0, "R8");
        traffic(0, 0, "R8");

        // R7 commands on absent line
        issue(INV, 32'h000, 0, 0, 0, "R4");
        snap();
        issue(INV, 32'h000, 0, 0, 0, "R7");
        issue(CLN, 32'h000, 0, 0, 0, "R7");
        issue(FLU, 32'h000, 0, 0, 0, "R7");
        traffic(0, 0, "R7");

        // R5 clean of dirty line B
        snap(); issue(CLN, 32'h040, 0, 0, 0, "R5");
        traffic(1, 0, "R5");
        check(bmem[18] == 32'h2222_2222, "R5", "cleaned word in memory", bmem[18], 32'h2222_2222);
        snap(); issue(LD, 32'h048, 0, 32'h2222_2222, 0, "R5");
        issue(CLN, 32'h040, 0, 0, 0, "R5");
        traffic(0, 0, "R5");
        issue(INV, 32'h040, 0, 0, 0, "R4");
        snap(); issue(LD, 32'h048, 0, 32'h2222_2222, 0, "R5");
        traffic(0, 1, "R5");

        // R6 flush dirty then flush clean
        issue(ST, 32'h04C, 32'h3333_3333, 0, 0, "R2");
        snap(); issue(FLU, 32'h040, 0, 0, 0, "R6");
        traffic(1, 0, "R6");
        check(bmem[19] == 32'h3333_3333, "R6", "flushed word in memory", bmem[19], 32'h3333_3333);
        snap(); issue(LD, 32'h04C, 0, 32'h3333_3333, 0, "R6");
        traffic(0, 1, "R6");
        snap(); issue(FLU, 32'h040, 0, 0, 0, "R6");
        traffic(0, 0, "R6");
        snap(); issue(LD, 32'h040, 0, bval(32'h040), 0, "R6");
        traffic(0, 1, "R6");

        // R3 victim handling
        snap(); issue(ST, 32'h010, 32'h4444_4444, 0, 0, "R2");
        traffic(0, 1, "R2");
        snap(); issue(LD, 32'h210, 0, bval(32'h210), 0, "R3");
        traffic(1, 1, "R3");
        check(bmem[4] == 32'h4444_4444, "R3", "victim word in memory", bmem[4], 32'h4444_4444);
        issue(ST, 32'h220, 32'h5555_5555, 0, 0, "R2");
        snap(); issue(ST, 32'h000, 32'h6666_6666, 0, 0, "R3");
        traffic(1, 1, "R3");
        check(bmem[136] == 32'h5555_5555, "R3", "second victim in memory", bmem[136], 32'h5555_5555);
        issue(LD, 32'h000, 0, 32'h6666_6666, 0, "R2");
        issue(LD, 32'h010, 0, 32'h4444_4444, 0, "R3");
        snap(); issue(LD, 32'h210, 0, bval(32'h210), 0, "R3");
        traffic(1, 1, "R3");

        // R9 uncached window
        snap();
        issue(INV, 32'hF000_0040, 0, 0, 1, "R9");
        issue(CLN, 32'hF000_0040, 0, 0, 1, "R9");
        issue(FLU, 32'hF000_0000, 0, 0, 1, "R9");
        traffic(0, 0, "R9");
        snap(); issue(LD, 32'h210, 0, bval(32'h210), 0, "R9");
        traffic(0, 0, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule